// File: doc/BRIEF.md
# Serial Programming Command Decoder

This block is the slave side of a four-byte serial programming link. A host shifts instructions in on `mosi`, timed by `sck`, while `cs_n` is held low. The block turns each complete frame into a read or write request for a 1024-word by 16-bit program store or a 128-byte data store. Read results and echo bytes go back on `miso` during the last byte of the same frame.

All serial inputs are resampled in the `clk` domain and their edges are detected there. The host must therefore hold each `sck` level for several `clk` periods. Nothing is carried out until an unlock frame has been seen. Chip erase is timed inside the block. A plain `ready` output lets the host poll for the end of self-timed writes and erase. A program-store read that hits the word being written returns all ones until the store drops its busy line.

The storage arrays sit outside the block. Their contract is as follows. A read request is answered with data on the next cycle. A write raises `mem_busy` from the cycle after the request until the write is done.

Top module: `sprog_cmd_decoder`

## Requirements
- R1: A frame is 32 bits taken from `mosi` at rising `sck` edges, most significant bit first. The first byte carries the opcode. Program-store addresses take their top two bits from the low bits of byte two and bits 7..0 from byte three.
- R2: Program read is first byte `0010 h000`, with h = bit 3. Byte four returns the high half of the addressed word when h=1 and the low half when h=0.
- R3: Program write is first byte `0100 h000`. Byte four is written into the half of the word that h selects. The other half is left unchanged.
- R4: Data-store read is first byte 0xA0, with the address in bits 6..0 of byte three. The stored byte is returned during byte four.
- R5: Data-store write is first byte 0xC0, with the address in bits 6..0 of byte three and the data in byte four.
- R6: Until a frame whose first two bytes are 0xAC and 0x53 has completed, every read returns 0 and every write or erase is dropped. The unlock frame returns its own third byte during byte four.
- R7: A program read of the word whose write is still pending (write issued, `mem_busy` not yet fallen) returns 0xFF for either half. Other addresses read normally.
- R8: Chip erase is first byte 0xAC with bits 7..5 of byte two equal to 100. It pulses `erase_req` and holds `ready` low for ERASE_CYCLES cycles. After it, every location reads 0xFF.
- R9: `ready` is low while `mem_busy` is high or an erase is running. Write and erase frames that end while `ready` is low are dropped.
- R10: Raising `cs_n` clears the bit position, so a partial frame has no effect and the next frame decodes normally.
- R11: `miso` changes only on falling `sck` edges or when `cs_n` goes high. It is 0 during the first three bytes of a frame.
- R12: At most one of `flash_req`, `ee_req` and `erase_req` is high in a cycle. Each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data to host |
| ready | output | 1 | High when no write or erase is in progress |
| flash_req | output | 1 | Program-store request pulse |
| flash_we | output | 1 | Program-store request is a write |
| flash_hi | output | 1 | Selects the high half of the word |
| flash_addr | output | FLASH_AW | Program-store word address |
| flash_wdata | output | 8 | Byte to write |
| flash_rdata | input | 16 | Word read, valid the cycle after a read request |
| ee_req | output | 1 | Data-store request pulse |
| ee_we | output | 1 | Data-store request is a write |
| ee_addr | output | EE_AW | Data-store byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_rdata | input | 8 | Byte read, valid the cycle after a read request |
| erase_req | output | 1 | Chip-erase pulse |
| mem_busy | input | 1 | Storage write in progress |

## Verification
The bench keeps the default 10-bit program and 7-bit data address widths. This lets directed reads reach the top word 1023 and byte 127 through the full address path. ERASE_CYCLES is reduced to 300 so that the whole erase window, and its end, can be timed within a short run. The bench's storage model keeps a write busy for 3000 cycles, which is longer than several frames. This brings polling reads, reads of other addresses, and dropped writes during one pending write within reach.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

  typedef enum logic [2:0] {
    K_NONE, K_FLASH_RD, K_FLASH_WR, K_EE_RD, K_EE_WR, K_UNLOCK, K_ERASE
  } cmd_e;

  localparam logic [7:0] OP_UNLOCK_A = 8'hAC;
  localparam logic [7:0] OP_UNLOCK_B = 8'h53;
  localparam logic [2:0] OP_ERASE_B  = 3'b100;
  localparam logic [3:0] OP_FRD      = 4'b0010;
  localparam logic [3:0] OP_FWR      = 4'b0100;
  localparam logic [7:0] OP_ERD      = 8'hA0;
  localparam logic [7:0] OP_EWR      = 8'hC0;

  // Classify a frame from its first two bytes.
  function automatic cmd_e classify(logic [7:0] b1, logic [7:0] b2);
    if (b1 == OP_UNLOCK_A && b2 == OP_UNLOCK_B)     return K_UNLOCK;
    if (b1 == OP_UNLOCK_A && b2[7:5] == OP_ERASE_B) return K_ERASE;
    if (b1[7:4] == OP_FRD && b1[2:0] == 3'b000)     return K_FLASH_RD;
    if (b1[7:4] == OP_FWR && b1[2:0] == 3'b000)     return K_FLASH_WR;
    if (b1 == OP_ERD)                               return K_EE_RD;
    if (b1 == OP_EWR)                               return K_EE_WR;
    return K_NONE;
  endfunction

  // Byte returned during the fourth byte of a frame.
  function automatic logic [7:0] resp_byte(cmd_e k, logic en, logic poll, logic hi,
                                           logic [15:0] fw, logic [7:0] ed,
                                           logic [7:0] echo);
    case (k)
      K_UNLOCK:   return echo;
      K_FLASH_RD: return !en ? 8'h00 : (poll ? 8'hFF : (hi ? fw[15:8] : fw[7:0]));
      K_EE_RD:    return en ? ed : 8'h00;
      default:    return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic cs_idle
);
  logic [STAGES-1:0] sck_p, mosi_p, cs_p;
  logic sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      mosi_p <= '0;
      cs_p   <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_p  <= {sck_p[STAGES-2:0], sck};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
      cs_p   <= {cs_p[STAGES-2:0], cs_n};
      sck_d  <= sck_p[STAGES-1];
    end
  end

  assign sck_rise = sck_p[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_p[STAGES-1] & sck_d;
  assign mosi_s   = mosi_p[STAGES-1];
  assign cs_idle  = cs_p[STAGES-1];
endmodule

// File: rtl/sprog_shifter.sv
module sprog_shifter #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_rise,
  input  logic                  sck_fall,
  input  logic                  mosi_s,
  input  logic                  cs_idle,
  input  logic                  load,
  input  logic [7:0]            load_val,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  resp_evt,
  output logic                  done_evt,
  output logic                  miso
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] RESP = CW'(FRAME_BITS - 9);

  logic [CW-1:0] cnt;
  logic [7:0]    out_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; frame <= '0; out_sr <= '0;
      resp_evt <= 1'b0; done_evt <= 1'b0; miso <= 1'b0;
    end else if (cs_idle) begin
      cnt <= '0; out_sr <= '0;
      resp_evt <= 1'b0; done_evt <= 1'b0; miso <= 1'b0;
    end else begin
      resp_evt <= 1'b0;
      done_evt <= 1'b0;
      if (sck_rise) begin
        frame    <= {frame[FRAME_BITS-2:0], mosi_s};
        cnt      <= (cnt == LAST) ? '0 : cnt + 1'b1;
        resp_evt <= (cnt == RESP);
        done_evt <= (cnt == LAST);
      end
      if (load) begin
        out_sr <= load_val;
      end else if (sck_fall) begin
        miso   <= out_sr[7];
        out_sr <= {out_sr[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sprog_erase_timer.sv
module sprog_erase_timer #(
  parameter int unsigned CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sprog_cmd_decoder.sv
module sprog_cmd_decoder
  import sprog_pkg::*;
#(
  parameter int          FLASH_AW     = 10,
  parameter int          EE_AW        = 7,
  parameter int unsigned ERASE_CYCLES = 100000,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                mosi,
  input  logic                cs_n,
  output logic                miso,
  output logic                ready,
  output logic                flash_req,
  output logic                flash_we,
  output logic                flash_hi,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic [7:0]          flash_wdata,
  input  logic [15:0]         flash_rdata,
  output logic                ee_req,
  output logic                ee_we,
  output logic [EE_AW-1:0]    ee_addr,
  output logic [7:0]          ee_wdata,
  input  logic [7:0]          ee_rdata,
  output logic                erase_req,
  input  logic                mem_busy
);
  localparam int FB = 32;

  logic sck_rise_w, sck_fall_w, mosi_s, cs_idle_w;
  logic resp_evt, done_evt, load;
  logic [FB-1:0] frame;
  logic [7:0] load_val;

  sprog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .sck_rise(sck_rise_w), .sck_fall(sck_fall_w), .mosi_s(mosi_s), .cs_idle(cs_idle_w));

  sprog_shifter #(.FRAME_BITS(FB)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise_w), .sck_fall(sck_fall_w),
    .mosi_s(mosi_s), .cs_idle(cs_idle_w), .load(load), .load_val(load_val),
    .frame(frame), .resp_evt(resp_evt), .done_evt(done_evt), .miso(miso));

  // Decode views: after 24 bits byte1..3 sit in frame[23:0]; after 32 in frame[31:0].
  cmd_e c_resp, c_done;
  assign c_resp = classify(frame[23:16], frame[15:8]);
  assign c_done = classify(frame[31:24], frame[23:16]);

  logic [FLASH_AW-1:0] rd_faddr, wr_faddr;
  logic [EE_AW-1:0]    rd_eaddr, wr_eaddr;
  assign rd_faddr = frame[FLASH_AW-1:0];
  assign wr_faddr = frame[FLASH_AW+7:8];
  assign rd_eaddr = frame[EE_AW-1:0];
  assign wr_eaddr = frame[EE_AW+7:8];

  logic prog_en, erase_busy, write_ok, erase_go;
  logic rs1, rs2, rsp_en, poll_q, pend_v, busy_q;
  cmd_e rsp_kind;
  logic [7:0] echo_q;
  logic [FLASH_AW-1:0] pend_addr;

  assign ready    = !mem_busy && !erase_busy && !(flash_req && flash_we) && !(ee_req && ee_we);
  assign write_ok = prog_en && ready;
  assign erase_go = done_evt && write_ok && (c_done == K_ERASE);

  sprog_erase_timer #(.CYCLES(ERASE_CYCLES)) u_erase (
    .clk(clk), .rst_n(rst_n), .start(erase_go), .busy(erase_busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flash_req <= 1'b0; flash_we <= 1'b0; flash_hi <= 1'b0;
      flash_addr <= '0; flash_wdata <= '0;
      ee_req <= 1'b0; ee_we <= 1'b0; ee_addr <= '0; ee_wdata <= '0;
      erase_req <= 1'b0; prog_en <= 1'b0;
      rs1 <= 1'b0; rs2 <= 1'b0; rsp_en <= 1'b0; poll_q <= 1'b0;
      rsp_kind <= K_NONE; echo_q <= '0;
      pend_v <= 1'b0; pend_addr <= '0; busy_q <= 1'b0;
    end else begin
      flash_req <= 1'b0;
      ee_req    <= 1'b0;
      erase_req <= erase_go;
      rs2       <= rs1;
      rs1       <= 1'b0;
      busy_q    <= mem_busy;
      if (busy_q && !mem_busy) pend_v <= 1'b0;

      if (resp_evt) begin
        rs1      <= 1'b1;
        rsp_kind <= c_resp;
        rsp_en   <= prog_en;
        echo_q   <= frame[7:0];
        poll_q   <= pend_v && (pend_addr == rd_faddr);
        if (prog_en && c_resp == K_FLASH_RD) begin
          flash_req <= 1'b1; flash_we <= 1'b0;
          flash_addr <= rd_faddr; flash_hi <= frame[19];
        end
        if (prog_en && c_resp == K_EE_RD) begin
          ee_req <= 1'b1; ee_we <= 1'b0; ee_addr <= rd_eaddr;
        end
      end

      if (done_evt) begin
        if (c_done == K_UNLOCK) prog_en <= 1'b1;
        if (write_ok && c_done == K_FLASH_WR) begin
          flash_req <= 1'b1; flash_we <= 1'b1; flash_hi <= frame[27];
          flash_addr <= wr_faddr; flash_wdata <= frame[7:0];
          pend_v <= 1'b1; pend_addr <= wr_faddr;
        end
        if (write_ok && c_done == K_EE_WR) begin
          ee_req <= 1'b1; ee_we <= 1'b1; ee_addr <= wr_eaddr; ee_wdata <= frame[7:0];
        end
      end
    end
  end

  // Response byte is loaded two cycles after the read is issued: request, then data.
  assign load     = rs2;
  assign load_val = resp_byte(rsp_kind, rsp_en, poll_q, flash_hi, flash_rdata, ee_rdata, echo_q);
endmodule

// File: rtl/sprog_checker.sv
module sprog_checker (
  input logic clk,
  input logic rst_n,
  input logic fall_evt,
  input logic cs_idle,
  input logic miso,
  input logic flash_req,
  input logic flash_we,
  input logic ee_req,
  input logic ee_we,
  input logic erase_req,
  input logic ready,
  input logic prog_en,
  input logic erase_busy
);
  assert_one_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flash_req, ee_req, erase_req}));

  assert_flash_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flash_req |=> !flash_req);

  assert_ee_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req |=> !ee_req);

  assert_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_req || ee_req || erase_req) |-> prog_en);

  assert_write_when_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flash_req && flash_we) || (ee_req && ee_we) || erase_req) |-> $past(ready));

  assert_erase_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (erase_busy && !ready));

  assert_miso_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_evt && !cs_idle) |=> $stable(miso));
endmodule

bind sprog_cmd_decoder sprog_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fall_evt(sck_fall_w), .cs_idle(cs_idle_w), .miso(miso),
  .flash_req(flash_req), .flash_we(flash_we), .ee_req(ee_req), .ee_we(ee_we),
  .erase_req(erase_req), .ready(ready), .prog_en(prog_en), .erase_busy(erase_busy));

// File: tb/tb_sprog_cmd_decoder.sv
module tb_sprog_cmd_decoder;
  localparam int HALF = 8;
  localparam int ERASE_CYC = 300;
  localparam int FWR_BUSY = 3000;
  localparam int EWR_BUSY = 200;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sck, mosi, cs_n, miso, ready;
  logic flash_req, flash_we, flash_hi, ee_req, ee_we, erase_req, mem_busy;
  logic [9:0] flash_addr;
  logic [7:0] flash_wdata, ee_wdata, ee_rdata;
  logic [15:0] flash_rdata;
  logic [6:0] ee_addr;

  sprog_cmd_decoder #(.ERASE_CYCLES(ERASE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso),
    .ready(ready), .flash_req(flash_req), .flash_we(flash_we), .flash_hi(flash_hi),
    .flash_addr(flash_addr), .flash_wdata(flash_wdata), .flash_rdata(flash_rdata),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_rdata(ee_rdata), .erase_req(erase_req), .mem_busy(mem_busy));

  function automatic logic [15:0] init_f(int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction
  function automatic logic [7:0] init_e(int i);
    return 8'(i * 7 + 3);
  endfunction

  // Storage model: synchronous read, busy from the cycle after a write.
  logic [15:0] fmem [1024];
  logic [7:0]  emem [128];
  int bcnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= 0;
      for (int i = 0; i < 1024; i++) fmem[i] <= init_f(i);
      for (int i = 0; i < 128; i++)  emem[i] <= init_e(i);
    end else begin
      if (bcnt != 0) bcnt <= bcnt - 1;
      if (flash_req && flash_we) begin
        if (flash_hi) fmem[flash_addr][15:8] <= flash_wdata;
        else          fmem[flash_addr][7:0]  <= flash_wdata;
        bcnt <= FWR_BUSY;
      end
      if (ee_req && ee_we) begin
        emem[ee_addr] <= ee_wdata;
        bcnt <= EWR_BUSY;
      end
      if (erase_req) begin
        for (int i = 0; i < 1024; i++) fmem[i] <= 16'hFFFF;
        for (int i = 0; i < 128; i++)  emem[i] <= 8'hFF;
      end
      if (flash_req && !flash_we) flash_rdata <= fmem[flash_addr];
      if (ee_req && !ee_we)       ee_rdata    <= emem[ee_addr];
    end
  end
  assign mem_busy = (bcnt != 0);

  // Shadow of expected contents.
  logic [15:0] sh_f [1024];
  logic [7:0]  sh_e [128];
  function automatic logic [7:0] exp_fbyte(int a, logic hi);
    return hi ? sh_f[a][15:8] : sh_f[a][7:0];
  endfunction

  int checks = 0, errors = 0, multi = 0, repeats = 0;
  logic fq_d, eq_d;
  always @(posedge clk) begin
    fq_d <= flash_req; eq_d <= ee_req;
    if (rst_n) begin
      if (32'(flash_req) + 32'(ee_req) + 32'(erase_req) > 1) multi <= multi + 1;
      if ((flash_req && fq_d) || (ee_req && eq_d)) repeats <= repeats + 1;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] b1, b2, b3, b4, output logic [7:0] rx,
                       output logic other);
    logic [31:0] w;
    w = {b1, b2, b3, b4};
    rx = 8'h00; other = 1'b0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 31; i >= 0; i--) begin
      mosi = w[i];
      repeat (HALF) @(negedge clk);
      if (i < 8) rx = {rx[6:0], miso};
      else       other = other | miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic f_rd(input int a, input logic hi, output logic [7:0] rx);
    logic o;
    frame({4'b0010, hi, 3'b000}, {6'b0, 2'(a >> 8)}, 8'(a), 8'h00, rx, o);
    chk(32'(o), 0, "R11 miso idle in bytes 1-3");
  endtask
  task automatic f_wr(input int a, input logic hi, input logic [7:0] d);
    logic [7:0] rx; logic o;
    frame({4'b0100, hi, 3'b000}, {6'b0, 2'(a >> 8)}, 8'(a), d, rx, o);
  endtask
  task automatic e_rd(input int a, output logic [7:0] rx);
    logic o;
    frame(8'hA0, 8'h00, {1'b0, 7'(a)}, 8'h00, rx, o);
  endtask
  task automatic e_wr(input int a, input logic [7:0] d);
    logic [7:0] rx; logic o;
    frame(8'hC0, 8'h00, {1'b0, 7'(a)}, d, rx, o);
  endtask
  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 20000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual expired expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx; logic o; int n;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 1024; i++) sh_f[i] = init_f(i);
    for (int i = 0; i < 128; i++)  sh_e[i] = init_e(i);
    rst_n = 1'b0; sck = 1'b0; mosi = 1'b0; cs_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(32'(miso), 0, "R11 reset miso");
    chk(32'(ready), 1, "R9 reset ready");
    chk(32'(flash_req | ee_req | erase_req), 0, "R12 reset requests");

    // Locked: write dropped, read returns 0.
    e_wr(5, 8'h77);
    e_rd(5, rx);
    chk(32'(rx), 0, "R6 locked read");
    frame(8'hAC, 8'h53, 8'h5A, 8'h00, rx, o);
    chk(32'(rx), 32'h5A, "R6 unlock echo");
    e_rd(5, rx);
    chk(32'(rx), 32'(sh_e[5]), "R6 locked write dropped");

    // Partial frame discarded.
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 13; i++) begin
      mosi = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b1;  repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    e_rd(9, rx);
    chk(32'(rx), 32'(sh_e[9]), "R10 after partial frame");

    // Address extremes.
    f_rd(1023, 1'b1, rx);
    chk(32'(rx), 32'(exp_fbyte(1023, 1'b1)), "R1 R2 top word high");
    f_rd(1023, 1'b0, rx);
    chk(32'(rx), 32'(exp_fbyte(1023, 1'b0)), "R2 top word low");
    e_rd(127, rx);
    chk(32'(rx), 32'(sh_e[127]), "R4 top byte");

    // Write, poll, dropped write.
    f_wr(677, 1'b0, 8'h3C);
    sh_f[677][7:0] = 8'h3C;
    chk(32'(ready), 0, "R9 busy after write");
    f_rd(677, 1'b0, rx);
    chk(32'(rx), 32'hFF, "R7 poll low");
    f_rd(677, 1'b1, rx);
    chk(32'(rx), 32'hFF, "R7 poll high");
    f_rd(12, 1'b0, rx);
    chk(32'(rx), 32'(exp_fbyte(12, 1'b0)), "R7 other address");
    e_wr(20, 8'hE1);
    wait_ready(n);
    chk(32'(ready), 1, "R9 ready returns");
    e_rd(20, rx);
    chk(32'(rx), 32'(sh_e[20]), "R9 write dropped while busy");
    f_rd(677, 1'b0, rx);
    chk(32'(rx), 32'h3C, "R3 written low");
    f_rd(677, 1'b1, rx);
    chk(32'(rx), 32'(exp_fbyte(677, 1'b1)), "R3 high half kept");

    // Random operations.
    for (int k = 0; k < 24; k++) begin
      int op, a; logic hi; logic [7:0] d;
      op = int'($urandom % 4); a = int'($urandom % 1024);
      hi = 1'($urandom); d = 8'($urandom);
      case (op)
        0: begin
          f_wr(a, hi, d);
          if (hi) sh_f[a][15:8] = d; else sh_f[a][7:0] = d;
          wait_ready(n);
          f_rd(a, hi, rx);
          chk(32'(rx), 32'(exp_fbyte(a, hi)), "R3 random write");
        end
        1: begin
          e_wr(a % 128, d); sh_e[a % 128] = d;
          wait_ready(n);
          e_rd(a % 128, rx);
          chk(32'(rx), 32'(sh_e[a % 128]), "R5 random write");
        end
        2: begin
          f_rd(a, hi, rx);
          chk(32'(rx), 32'(exp_fbyte(a, hi)), "R2 random read");
        end
        default: begin
          e_rd(a % 128, rx);
          chk(32'(rx), 32'(sh_e[a % 128]), "R4 random read");
        end
      endcase
    end

    // Chip erase.
    wait_ready(n);
    frame(8'hAC, 8'h80, 8'h00, 8'h00, rx, o);
    chk(32'(ready), 0, "R8 erase busy");
    wait_ready(n);
    chk(32'(n >= ERASE_CYC - 30 && n <= ERASE_CYC), 1, "R8 erase length");
    f_rd(300, 1'b1, rx);
    chk(32'(rx), 32'hFF, "R8 program erased");
    e_rd(40, rx);
    chk(32'(rx), 32'hFF, "R8 data erased");

    chk(32'(multi), 0, "R12 exclusive requests");
    chk(32'(repeats), 0, "R12 single-cycle pulses");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule